// File: doc/BRIEF.md
# Framer Alarm Event Counter Bank

This block keeps three small alarm tallies for a T1/E1 receive framer and presents them together as one byte-wide status word. The low two bits count severely errored frames. The next two bits count changes of frame alignment, which happen when a reframe moves the receive timebase to a new bit position. The high four bits count loss-of-frame events. Each tally advances by one on a single-cycle strobe from the framer. Event detection is done elsewhere.

Firmware reads the word with a one-cycle read strobe. The value on `rd_data_o` during that cycle is the value taken, and all three fields restart from zero. An event that arrives in the same cycle as a read is counted after the clear, so it is not lost. The two 2-bit fields wrap without notice. When the 4-bit loss-of-frame field wraps, a sticky interrupt flag is set and stays set until it is acknowledged. In E1 operation, loss-of-frame events come once per 8 ms alignment search interval, so the interrupt marks more than 100 ms without alignment. The alignment-change field counts only in T1 mode.

All pins are plain control and status signals. There is no streaming interface, so no back-pressure applies.

Top module: `frm_alarm_cnt_bank`

## Requirements
- R1: While reset is held and after it is released, `rd_data_o` is 0x00 and `lof_irq_o` is 0.
- R2: Each `sef_evt_i` pulse increments bits [1:0] by one in the next cycle. The field wraps from 3 to 0 and does not change `lof_irq_o`.
- R3: With `t1_mode_i`=1, each `cofa_evt_i` pulse increments bits [3:2] by one in the next cycle. The field wraps from 3 to 0 and does not change `lof_irq_o`.
- R4: With `t1_mode_i`=0 (E1), `cofa_evt_i` is ignored and bits [3:2] read 0 from the next cycle on.
- R5: Each `lof_evt_i` pulse increments bits [7:4] by one in the next cycle.
- R6: The value on `rd_data_o` in a cycle with `rd_stb_i`=1 is the value read. In the next cycle all three fields are 0, unless an event arrived during the read.
- R7: An event strobe that coincides with `rd_stb_i` leaves its field at 1 after the clear.
- R8: A `lof_evt_i` pulse while bits [7:4] are 15, with no read in that cycle, wraps the field to 0 and sets `lof_irq_o` in the next cycle. The flag then stays set.
- R9: `irq_ack_i` clears `lof_irq_o` in the next cycle. A read does not clear the flag. If an overflow and an acknowledge happen in the same cycle, the flag stays set.
- R10: Strobes to different fields in the same cycle are all counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sef_evt_i | input | 1 | Severely errored frame strobe |
| cofa_evt_i | input | 1 | Alignment-change strobe |
| lof_evt_i | input | 1 | Loss-of-frame strobe |
| t1_mode_i | input | 1 | 1 = T1, 0 = E1 |
| rd_stb_i | input | 1 | Read strobe; clears all fields |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| rd_data_o | output | 8 | Packed counts {lof, cofa, sef} |
| lof_irq_o | output | 1 | Sticky loss-of-frame overflow flag |

## Verification
`rd_data_o` is a direct view of the count registers, so a wrong count shows in the packed byte one cycle after the strobe that caused it. That same cycle is when the bench compares the byte against its model. A wrongly held flag or a missed overflow shows on `lof_irq_o` in the cycle after the sixteenth loss-of-frame strobe. An ignored acknowledge shows in the cycle after the acknowledge. Faults in read clearing and in mode gating show in the first cycle after the read or the mode change.

// File: rtl/frm_alarm_pkg.sv
package frm_alarm_pkg;
  // Field widths of the packed status byte, low field first.
  localparam int SEF_W  = 2;
  localparam int COFA_W = 2;
  localparam int LOF_W  = 4;
  localparam int WORD_W = SEF_W + COFA_W + LOF_W;

  typedef struct packed {
    logic [LOF_W-1:0]  lof;
    logic [COFA_W-1:0] cofa;
    logic [SEF_W-1:0]  sef;
  } alarm_word_t;
endpackage

// File: rtl/frm_evt_ctr.sv
module frm_evt_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  logic         clr_i,
  input  logic         hold_zero_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, base, nxt;

  always_comb begin
    base = clr_i ? '0 : cnt_q;
    nxt  = base + W'(evt_i);
    if (hold_zero_i) nxt = '0;
  end

  assign wrap_o = evt_i && !hold_zero_i && (base == MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;

  // R2 R3 R5
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !clr_i && !hold_zero_i && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + W'(1));
  // R2 R3 R8
  ctr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !clr_i && !hold_zero_i && cnt_q == MAX) |=> cnt_q == '0);
  // R6
  ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> cnt_q == '0);
  // R7
  ctr_rdhit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i && !hold_zero_i) |=> cnt_q == W'(1));
  // R4
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero_i |=> cnt_q == '0);
  ctr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i && !clr_i && !hold_zero_i) |=> $stable(cnt_q));
endmodule

// File: rtl/frm_sticky_flag.sv
module frm_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack_i) |=> flag_q);
  // R9
  flag_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !flag_q);
  // R2 R3
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !set_i) |=> !flag_q);
endmodule

// File: rtl/frm_alarm_cnt_bank.sv
module frm_alarm_cnt_bank
  import frm_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sef_evt_i,
  input  logic              cofa_evt_i,
  input  logic              lof_evt_i,
  input  logic              t1_mode_i,
  input  logic              rd_stb_i,
  input  logic              irq_ack_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              lof_irq_o
);
  alarm_word_t word;
  logic sef_wrap, cofa_wrap, lof_wrap;

  frm_evt_ctr #(.W(SEF_W)) u_sef (
    .clk(clk), .rst_n(rst_n), .evt_i(sef_evt_i), .clr_i(rd_stb_i),
    .hold_zero_i(1'b0), .cnt_o(word.sef), .wrap_o(sef_wrap));

  frm_evt_ctr #(.W(COFA_W)) u_cofa (
    .clk(clk), .rst_n(rst_n), .evt_i(cofa_evt_i), .clr_i(rd_stb_i),
    .hold_zero_i(!t1_mode_i), .cnt_o(word.cofa), .wrap_o(cofa_wrap));

  frm_evt_ctr #(.W(LOF_W)) u_lof (
    .clk(clk), .rst_n(rst_n), .evt_i(lof_evt_i), .clr_i(rd_stb_i),
    .hold_zero_i(1'b0), .cnt_o(word.lof), .wrap_o(lof_wrap));

  frm_sticky_flag u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(lof_wrap), .ack_i(irq_ack_i),
    .flag_o(lof_irq_o));

  assign rd_data_o = word;

  // R1
  rst_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (rd_data_o == '0 && !lof_irq_o));
  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !sef_evt_i && !cofa_evt_i && !lof_evt_i) |=> rd_data_o == '0);
  // R4
  e1_cofa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !t1_mode_i |=> rd_data_o[3:2] == 2'b00);
  // R8
  lof_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lof_evt_i && !rd_stb_i && rd_data_o[7:4] == 4'hF) |=> (lof_irq_o && rd_data_o[7:4] == 4'h0));
  // R2 R3
  small_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lof_wrap && !lof_irq_o) |=> !lof_irq_o);
  // R9
  rd_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lof_irq_o && rd_stb_i && !irq_ack_i) |=> lof_irq_o);
endmodule

// File: tb/frm_alarm_cnt_bank_bench.sv
module frm_alarm_cnt_bank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sef_evt_i = 0, cofa_evt_i = 0, lof_evt_i = 0, t1_mode_i = 1;
  logic rd_stb_i = 0, irq_ack_i = 0;
  logic [7:0] rd_data_o;
  logic lof_irq_o;

  always #4 clk = ~clk;

  frm_alarm_cnt_bank u_frm_alarm_cnt_bank (
    .clk(clk), .rst_n(rst_n), .sef_evt_i(sef_evt_i), .cofa_evt_i(cofa_evt_i),
    .lof_evt_i(lof_evt_i), .t1_mode_i(t1_mode_i), .rd_stb_i(rd_stb_i),
    .irq_ack_i(irq_ack_i), .rd_data_o(rd_data_o), .lof_irq_o(lof_irq_o));

  typedef struct {
    logic [7:0] data;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  logic [1:0] m_sef = 0, m_cofa = 0;
  logic [3:0] m_lof = 0;
  logic       m_irq = 0;

  task automatic step(input bit s, input bit c, input bit l, input bit t1,
                      input bit rd, input bit ack, input string tag);
    logic [1:0] bs, bc;
    logic [3:0] bl;
    exp_t e;
    sef_evt_i = s; cofa_evt_i = c; lof_evt_i = l;
    t1_mode_i = t1; rd_stb_i = rd; irq_ack_i = ack;
    bs = rd ? 2'd0 : m_sef;
    bc = rd ? 2'd0 : m_cofa;
    bl = rd ? 4'd0 : m_lof;
    if (l && bl == 4'hF) m_irq = 1'b1;
    else if (ack)        m_irq = 1'b0;
    m_sef  = bs + 2'(s);
    m_cofa = t1 ? bc + 2'(c) : 2'd0;
    m_lof  = bl + 4'(l);
    @(posedge clk);
    #1;
    e.data = {m_lof, m_cofa, m_sef};
    e.irq  = m_irq;
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compares one expectation per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rd_data_o !== e.data || lof_irq_o !== e.irq) begin
        errors++;
        $display("FAIL %s: data=%02h irq=%b expected data=%02h irq=%b",
                 e.tag, rd_data_o, lof_irq_o, e.data, e.irq);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: data=%02h irq=%b expected run to finish",
               rd_data_o, lof_irq_o);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    checks++;
    if (rd_data_o !== 8'h00 || lof_irq_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: data=%02h irq=%b expected data=00 irq=0", rd_data_o, lof_irq_o);
    end
    rst_n = 1'b1;
    step(0,0,0,1,0,0,"R1 idle after reset");
    // R2: count and wrap the low field
    for (int i = 0; i < 4; i++) step(1,0,0,1,0,0,"R2 sef count/wrap");
    // R3: T1 alignment-change count and wrap
    for (int i = 0; i < 5; i++) step(0,1,0,1,0,0,"R3 cofa count/wrap");
    // R4: E1 mode ignores strobes and zeroes the field
    step(0,1,0,0,0,0,"R4 e1 hold zero");
    step(0,1,0,0,0,0,"R4 e1 ignore strobe");
    // R5: loss-of-frame counts
    for (int i = 0; i < 5; i++) step(0,0,1,1,0,0,"R5 lof count");
    step(1,1,0,1,0,0,"R10 mixed events");
    // R6: read clears every field
    step(0,0,0,1,1,0,"R6 read clears");
    step(1,1,1,1,0,0,"R10 all three at once");
    step(1,0,1,1,0,0,"R10 two fields");
    // R7: events during a read count after the clear
    step(1,1,1,1,1,0,"R7 event with read");
    step(0,0,0,1,1,0,"R6 read clears");
    // R8: overflow of the wide field
    for (int i = 0; i < 15; i++) step(0,0,1,0,0,0,"R5 lof to max");
    step(0,0,1,0,0,0,"R8 lof overflow sets irq");
    step(0,0,0,0,0,0,"R8 irq sticky");
    step(0,0,1,0,1,0,"R9 read keeps irq");
    step(0,0,0,0,0,1,"R9 ack clears irq");
    step(0,0,0,0,0,0,"R9 irq stays clear");
    for (int i = 0; i < 14; i++) step(0,0,1,0,0,0,"R5 lof to max");
    step(0,0,1,0,0,1,"R9 overflow beats ack");
    step(0,0,0,0,0,1,"R9 ack clears");
    // R7: event at read with the wide field full does not overflow
    for (int i = 0; i < 15; i++) step(0,0,1,1,0,0,"R5 lof to max");
    step(0,0,1,1,1,0,"R7 read at max no irq");
    step(0,0,0,1,0,0,"R7 idle");
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule